// File: doc/BRIEF.md
# Debug Halt Control and Status

This block is the register face of a processor's halting debug logic. A debugger reaches it through a small word-indexed bus port, and the block turns those accesses into halt, single-step and interrupt-mask requests toward the core. A single debug-enable bit gates all three requests. A 16-bit key must accompany every write to the control word. Without it the write is thrown away, so a stray store cannot stop the core.

The same word reads back as status. It shows the live core flags (halted, sleeping, locked up), whether a core-register transfer can be issued, and two sticky event flags: a core reset was seen, and an instruction retired. Both sticky flags clear when the word is read. A separate reason register collects write-one-to-clear flags that tell why the core stopped. A third register holds the vector-catch and watchpoint-unit enables.

A selector/data register pair moves values between the debugger and the core's register file while the core is halted. A selector write starts a request/acknowledge handshake with the core. The data register is the value sent on a write transfer and the value captured on a read transfer.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to index 0 changes the control bits only when bus_wdata[31:16] equals 0xA05F. Any other write to index 0 is discarded completely.
- R2: The control bits are enable (bit 0), halt (bit 1), step (bit 2) and interrupt mask (bit 3). They read back in the same positions at index 0.
- R3: halt_req, step_req and the interrupt mask are active only while the enable bit is 1. With enable at 0 they have no effect, whatever the other control bits hold.
- R4: Index 0 reads transfer-ready in bit 16, core halted in bit 17, sleeping in bit 18 and lockup in bit 19.
- R5: Bit 25 of index 0 is set by a core_reset_evt pulse. It clears on the clock edge that ends a read of index 0. If a pulse arrives in the same cycle as that read, the bit stays set.
- R6: Bit 24 of index 0 behaves in the same way, driven by core_retire.
- R7: Index 4 holds five reason flags: request/step halt (bit 0), breakpoint (bit 1), watchpoint (bit 2), vector catch (bit 3) and external request (bit 4). A halt_evt bit sets its flag. Writing 1 to a bit clears that flag. If a set and a clear meet in the same cycle, the set wins.
- R8: Index 1 takes the core register number in bits 4:0 and the direction in bit 16 (1 = write the core register, 0 = read it). A selector write is accepted only while core_halted is 1 and no transfer is pending. When accepted, xfer_req rises and the ready flag (index 0 bit 16) reads 0 from the next cycle. The ready flag returns, and xfer_req falls, on the cycle after xfer_ack. Any other selector write is ignored.
- R9: Index 2 is the data register. On an acknowledged read transfer it captures xfer_rdata. On a write transfer, xfer_wdata carries its value and the register keeps that value.
- R10: Index 3 holds the catch-on-reset enable (bit 0), the catch-on-hard-fault enable (bit 10) and the watchpoint-unit enable (bit 24). All other bits read 0.
- R11: exc_out equals exc_in, except that lines 2 and up are forced to 0 while the interrupt mask is active. Lines 0 (non-maskable) and 1 (hard fault) always pass.
- R12: After reset, the control bits, enables, reason flags and sticky flags are 0, and no transfer is pending. Unmapped indices read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| core_halted | input | 1 | Core is in halted state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_reset_evt | input | 1 | Pulse: core was reset |
| core_retire | input | 1 | Pulse: an instruction retired |
| halt_evt | input | 5 | Pulses setting the reason flags |
| exc_in | input | NUM_EXC | Exception requests into the block |
| exc_out | output | NUM_EXC | Exception requests after masking |
| halt_req | output | 1 | Halt request to the core |
| step_req | output | 1 | Single-step request to the core |
| vc_reset_en | output | 1 | Catch on reset enable |
| vc_fault_en | output | 1 | Catch on hard fault enable |
| watch_en | output | 1 | Watchpoint unit enable |
| xfer_req | output | 1 | Core register transfer pending |
| xfer_wr | output | 1 | Transfer direction, 1 = write core register |
| xfer_sel | output | 5 | Core register number |
| xfer_wdata | output | 32 | Value for a write transfer |
| xfer_ack | input | 1 | Core completed the transfer |
| xfer_rdata | input | 32 | Value returned by a read transfer |

## Verification
Two pairs of events can land on the same clock edge. The first is a read of the status word that clears the sticky flags, together with a new core_reset_evt pulse. The bench drives the pulse during that read and then reads again, expecting the flag still set. The second is a write-one-to-clear of a reason flag together with a fresh halt_evt for the same bit; the bench expects the flag to survive while the other cleared bits stay clear.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    // Key that must sit in the upper half of a control write
    localparam logic [15:0] CTRL_KEY = 16'hA05F;

    // Register word indices
    localparam int IDX_CTRL   = 0;
    localparam int IDX_SEL    = 1;
    localparam int IDX_DATA   = 2;
    localparam int IDX_VCATCH = 3;
    localparam int IDX_REASON = 4;
    localparam int NUM_REGS   = 5;

    // Status bit positions in the control word
    localparam int ST_READY   = 16;
    localparam int ST_HALTED  = 17;
    localparam int ST_SLEEP   = 18;
    localparam int ST_LOCKUP  = 19;
    localparam int ST_RETIRE  = 24;
    localparam int ST_RESET   = 25;

    // Selector direction bit and enable bit positions
    localparam int SEL_DIR_BIT = 16;
    localparam int VC_RST_BIT  = 0;
    localparam int VC_FLT_BIT  = 10;
    localparam int VC_WDT_BIT  = 24;

    localparam int REASON_W = 5;

    typedef struct packed {
        logic mask_ints;
        logic step;
        logic halt;
        logic enable;
    } dbg_ctrl_t;

    typedef struct packed {
        logic watch_en;
        logic vc_fault;
        logic vc_reset;
    } dbg_vc_t;

    typedef struct packed {
        logic       busy;
        logic       dir;
        logic [4:0] sel;
    } xfer_state_t;

    function automatic logic [31:0] pack_status(
        input dbg_ctrl_t ctrl,
        input logic      ready,
        input logic      halted,
        input logic      sleeping,
        input logic      lockup,
        input logic      retire_st,
        input logic      reset_st
    );
        logic [31:0] w;
        w            = '0;
        w[3:0]       = ctrl;
        w[ST_READY]  = ready;
        w[ST_HALTED] = halted;
        w[ST_SLEEP]  = sleeping;
        w[ST_LOCKUP] = lockup;
        w[ST_RETIRE] = retire_st;
        w[ST_RESET]  = reset_st;
        return w;
    endfunction

    function automatic logic [31:0] pack_vcatch(input dbg_vc_t vc);
        logic [31:0] w;
        w             = '0;
        w[VC_RST_BIT] = vc.vc_reset;
        w[VC_FLT_BIT] = vc.vc_fault;
        w[VC_WDT_BIT] = vc.watch_en;
        return w;
    endfunction

endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
    import dbg_halt_pkg::*;
#(
    parameter int NUM_EXC  = 8,
    parameter int NUM_PROT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic [15:0]        wr_key,
    input  logic [3:0]         wr_ctrl_bits,
    input  logic               wr_vc,
    input  dbg_vc_t            wr_vc_bits,
    input  logic [NUM_EXC-1:0] exc_in,
    output logic [NUM_EXC-1:0] exc_out,
    output dbg_ctrl_t          ctrl_q,
    output dbg_vc_t            vc_q,
    output logic               halt_req,
    output logic               step_req
);

    logic key_ok;
    logic mask_active;

    assign key_ok = wr_ctrl && (wr_key == CTRL_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (key_ok) begin
            ctrl_q <= dbg_ctrl_t'(wr_ctrl_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vc_q <= '0;
        end else if (wr_vc) begin
            vc_q <= wr_vc_bits;
        end
    end

    // Every control is inert unless debug is enabled
    always_comb begin
        halt_req    = ctrl_q.enable && ctrl_q.halt;
        step_req    = ctrl_q.enable && ctrl_q.step;
        mask_active = ctrl_q.enable && ctrl_q.mask_ints;
    end

    // Low lines (non-maskable, hard fault) are never masked
    for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
        if (i < NUM_PROT) begin : g_prot
            assign exc_out[i] = exc_in[i];
        end else begin : g_mask
            assign exc_out[i] = exc_in[i] && !mask_active;
        end
    end

endmodule

// File: rtl/dbg_sticky_status.sv
module dbg_sticky_status
    import dbg_halt_pkg::*;
#(
    parameter int NUM_REASON = REASON_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_status,
    input  logic                  wr_reason,
    input  logic [NUM_REASON-1:0] clr_bits,
    input  logic                  reset_evt,
    input  logic                  retire_evt,
    input  logic [NUM_REASON-1:0] halt_evt,
    output logic                  reset_st,
    output logic                  retire_st,
    output logic [NUM_REASON-1:0] reason_q
);

    // Sticky event flags: a new event beats the clear-on-read
    always_ff @(posedge clk) begin
        if (rst) begin
            reset_st  <= 1'b0;
            retire_st <= 1'b0;
        end else begin
            reset_st  <= reset_evt  || (reset_st  && !rd_status);
            retire_st <= retire_evt || (retire_st && !rd_status);
        end
    end

    // Halt reason flags, write-one-to-clear, set wins
    for (genvar i = 0; i < NUM_REASON; i++) begin : g_reason
        logic clr_i;
        assign clr_i = wr_reason && clr_bits[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                reason_q[i] <= 1'b0;
            end else begin
                reason_q[i] <= halt_evt[i] || (reason_q[i] && !clr_i);
            end
        end
    end

endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer
    import dbg_halt_pkg::*;
#(
    parameter int SEL_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [SEL_W-1:0]  sel_bits,
    input  logic              dir_bit,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_bits,
    input  logic              core_halted,
    input  logic              xfer_ack,
    input  logic [DATA_W-1:0] xfer_rdata,
    output logic              busy,
    output logic              dir_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] data_q
);

    logic accept;
    logic done;

    assign accept = wr_sel && core_halted && !busy;
    assign done   = busy && xfer_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            dir_q <= 1'b0;
            sel_q <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            dir_q <= dir_bit;
            sel_q <= sel_bits;
        end else if (done) begin
            busy  <= 1'b0;
        end
    end

    // Data register: bus write, or capture on a finished read transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (done && !dir_q) begin
            data_q <= xfer_rdata;
        end else if (wr_data) begin
            data_q <= data_bits;
        end
    end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int NUM_EXC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               core_halted,
    input  logic               core_sleeping,
    input  logic               core_lockup,
    input  logic               core_reset_evt,
    input  logic               core_retire,
    input  logic [4:0]         halt_evt,
    input  logic [NUM_EXC-1:0] exc_in,
    output logic [NUM_EXC-1:0] exc_out,
    output logic               halt_req,
    output logic               step_req,
    output logic               vc_reset_en,
    output logic               vc_fault_en,
    output logic               watch_en,
    output logic               xfer_req,
    output logic               xfer_wr,
    output logic [4:0]         xfer_sel,
    input  logic               xfer_ack,
    input  logic [31:0]        xfer_rdata,
    output logic [31:0]        xfer_wdata
);

    localparam int SEL_W  = 5;
    localparam int DATA_W = 32;

    logic [NUM_REGS-1:0] hit;
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g]    = bus_sel && (bus_addr == ADDR_W'(g));
        assign wr_hit[g] = hit[g] && bus_wr;
        assign rd_hit[g] = hit[g] && !bus_wr;
    end

    dbg_ctrl_t          ctrl_q;
    dbg_vc_t            vc_q;
    dbg_vc_t            vc_wr;
    logic               reset_st;
    logic               retire_st;
    logic [REASON_W-1:0] reason_q;
    logic               xfer_busy;
    logic               dir_q;
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  data_q;

    assign vc_wr.vc_reset = bus_wdata[VC_RST_BIT];
    assign vc_wr.vc_fault = bus_wdata[VC_FLT_BIT];
    assign vc_wr.watch_en = bus_wdata[VC_WDT_BIT];

    dbg_ctrl_regs #(
        .NUM_EXC  (NUM_EXC),
        .NUM_PROT (2)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_hit[IDX_CTRL]),
        .wr_key       (bus_wdata[31:16]),
        .wr_ctrl_bits (bus_wdata[3:0]),
        .wr_vc        (wr_hit[IDX_VCATCH]),
        .wr_vc_bits   (vc_wr),
        .exc_in       (exc_in),
        .exc_out      (exc_out),
        .ctrl_q       (ctrl_q),
        .vc_q         (vc_q),
        .halt_req     (halt_req),
        .step_req     (step_req)
    );

    dbg_sticky_status #(
        .NUM_REASON (REASON_W)
    ) u_sticky (
        .clk        (clk),
        .rst        (rst),
        .rd_status  (rd_hit[IDX_CTRL]),
        .wr_reason  (wr_hit[IDX_REASON]),
        .clr_bits   (bus_wdata[REASON_W-1:0]),
        .reset_evt  (core_reset_evt),
        .retire_evt (core_retire),
        .halt_evt   (halt_evt),
        .reset_st   (reset_st),
        .retire_st  (retire_st),
        .reason_q   (reason_q)
    );

    dbg_xfer #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .wr_sel      (wr_hit[IDX_SEL]),
        .sel_bits    (bus_wdata[SEL_W-1:0]),
        .dir_bit     (bus_wdata[SEL_DIR_BIT]),
        .wr_data     (wr_hit[IDX_DATA]),
        .data_bits   (bus_wdata),
        .core_halted (core_halted),
        .xfer_ack    (xfer_ack),
        .xfer_rdata  (xfer_rdata),
        .busy        (xfer_busy),
        .dir_q       (dir_q),
        .sel_q       (sel_q),
        .data_q      (data_q)
    );

    assign vc_reset_en = vc_q.vc_reset;
    assign vc_fault_en = vc_q.vc_fault;
    assign watch_en    = vc_q.watch_en;
    assign xfer_req    = xfer_busy;
    assign xfer_wr     = dir_q;
    assign xfer_sel    = sel_q;
    assign xfer_wdata  = data_q;

    always_comb begin
        bus_rdata = '0;
        if (hit[IDX_CTRL]) begin
            bus_rdata = pack_status(ctrl_q, !xfer_busy, core_halted,
                                    core_sleeping, core_lockup,
                                    retire_st, reset_st);
        end else if (hit[IDX_SEL]) begin
            bus_rdata[SEL_W-1:0]  = sel_q;
            bus_rdata[SEL_DIR_BIT] = dir_q;
        end else if (hit[IDX_DATA]) begin
            bus_rdata = data_q;
        end else if (hit[IDX_VCATCH]) begin
            bus_rdata = pack_vcatch(vc_q);
        end else if (hit[IDX_REASON]) begin
            bus_rdata[REASON_W-1:0] = reason_q;
        end
    end

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              halt_req,
    input logic              step_req,
    input logic              core_halted,
    input logic              core_reset_evt,
    input logic [4:0]        halt_evt,
    input logic [4:0]        reason_q,
    input logic              reset_st,
    input logic              xfer_req,
    input logic              xfer_ack
);

    logic ctrl_wr;
    logic sel_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign sel_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));

    assert_badkey_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[31:16] != 16'hA05F) |=> $stable({halt_req, step_req}));

    assert_disabled_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[31:16] == 16'hA05F && !bus_wdata[0]) |=> (!halt_req && !step_req));

    assert_reset_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        core_reset_evt |=> reset_st);

    assert_reason_set_R7: assert property (@(posedge clk) disable iff (rst)
        (|halt_evt) |=> ((reason_q & $past(halt_evt)) == $past(halt_evt)));

    assert_sel_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && core_halted && !xfer_req) |=> xfer_req);

    assert_sel_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && !core_halted && !xfer_req) |=> !xfer_req);

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_ack) |=> !xfer_req);

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .halt_req       (halt_req),
    .step_req       (step_req),
    .core_halted    (core_halted),
    .core_reset_evt (core_reset_evt),
    .halt_evt       (halt_evt),
    .reason_q       (reason_q),
    .reset_st       (reset_st),
    .xfer_req       (xfer_req),
    .xfer_ack       (xfer_ack)
);

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;

    localparam int ADDR_W  = 3;
    localparam int NUM_EXC = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               core_halted = 1'b0;
    logic               core_sleeping = 1'b0;
    logic               core_lockup = 1'b0;
    logic               core_reset_evt = 1'b0;
    logic               core_retire = 1'b0;
    logic [4:0]         halt_evt = '0;
    logic [NUM_EXC-1:0] exc_in = '0;
    logic [NUM_EXC-1:0] exc_out;
    logic               halt_req, step_req;
    logic               vc_reset_en, vc_fault_en, watch_en;
    logic               xfer_req, xfer_wr;
    logic [4:0]         xfer_sel;
    logic               xfer_ack = 1'b0;
    logic [31:0]        xfer_rdata = '0;
    logic [31:0]        xfer_wdata;

    always #4 clk = ~clk;

    dbg_halt_ctrl #(.ADDR_W(ADDR_W), .NUM_EXC(NUM_EXC)) u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_halted(core_halted), .core_sleeping(core_sleeping),
        .core_lockup(core_lockup), .core_reset_evt(core_reset_evt),
        .core_retire(core_retire), .halt_evt(halt_evt),
        .exc_in(exc_in), .exc_out(exc_out),
        .halt_req(halt_req), .step_req(step_req),
        .vc_reset_en(vc_reset_en), .vc_fault_en(vc_fault_en), .watch_en(watch_en),
        .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_sel(xfer_sel),
        .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata), .xfer_wdata(xfer_wdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    typedef struct packed {
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [2:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{3'd0, 32'hA05F_0003, 3'd0, 32'h0001_0003, 4'd2},  // R2 keyed write
        '{3'd0, 32'h1234_0000, 3'd0, 32'h0001_0003, 4'd1},  // R1 bad key dropped
        '{3'd0, 32'hA05F_000E, 3'd0, 32'h0001_000E, 4'd2},  // R2 all but enable
        '{3'd3, 32'hFFFF_FFFF, 3'd3, 32'h0100_0401, 4'd10}, // R10 only three bits
        '{3'd3, 32'h0000_0400, 3'd3, 32'h0000_0400, 4'd10}, // R10 fault only
        '{3'd2, 32'hDEAD_BEEF, 3'd2, 32'hDEAD_BEEF, 4'd9},  // R9 data register
        '{3'd1, 32'h0001_0005, 3'd1, 32'h0000_0000, 4'd8},  // R8 not halted: ignored
        '{3'd4, 32'h0000_001F, 3'd4, 32'h0000_0000, 4'd7},  // R7 clear of empty flags
        '{3'd5, 32'hFFFF_FFFF, 3'd5, 32'h0000_0000, 4'd12}  // R12 unmapped index
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        bus_read(3'd0, rd); check("R12 status", rd, 32'h0001_0000);
        bus_read(3'd3, rd); check("R12 enables", rd, 32'h0);
        bus_read(3'd4, rd); check("R12 reasons", rd, 32'h0);
        check("R12 requests", {30'b0, halt_req, xfer_req}, 32'h0);

        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R3 / R11: control is 0xE with enable clear
        exc_in = 8'hFF;
        @(negedge clk);
        check("R3 inert halt/step", {30'b0, halt_req, step_req}, 32'h0);
        check("R3 inert mask", {24'b0, exc_out}, 32'hFF);
        bus_write(3'd0, 32'hA05F_000F);
        check("R3 enabled halt/step", {30'b0, halt_req, step_req}, 32'h3);
        check("R11 masked keeps NMI/fault", {24'b0, exc_out}, 32'h03);
        bus_write(3'd0, 32'hA05F_0007);
        check("R11 unmasked", {24'b0, exc_out}, 32'hFF);
        bus_write(3'd0, 32'hA05F_0000);

        // R4 live core flags
        core_halted = 1'b1; core_sleeping = 1'b1; core_lockup = 1'b1;
        bus_read(3'd0, rd); check("R4 flags", rd, 32'h000F_0000);
        core_sleeping = 1'b0; core_lockup = 1'b0;

        // R5 sticky reset, clear on read, event during read survives
        @(negedge clk); core_reset_evt = 1'b1;
        @(negedge clk); core_reset_evt = 1'b0;
        bus_read(3'd0, rd); check("R5 set", rd & 32'h0200_0000, 32'h0200_0000);
        bus_read(3'd0, rd); check("R5 cleared by read", rd & 32'h0200_0000, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0; core_reset_evt = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; core_reset_evt = 1'b0;
        bus_read(3'd0, rd); check("R5 event beats read clear", rd & 32'h0200_0000, 32'h0200_0000);

        // R6 sticky retire
        @(negedge clk); core_retire = 1'b1;
        @(negedge clk); core_retire = 1'b0;
        bus_read(3'd0, rd); check("R6 set", rd & 32'h0100_0000, 32'h0100_0000);
        bus_read(3'd0, rd); check("R6 cleared by read", rd & 32'h0100_0000, 32'h0);

        // R7 reason flags
        @(negedge clk); halt_evt = 5'b10110;
        @(negedge clk); halt_evt = 5'b0;
        bus_read(3'd4, rd); check("R7 set", rd, 32'h16);
        bus_write(3'd4, 32'h2);
        bus_read(3'd4, rd); check("R7 clear one", rd, 32'h14);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h14; halt_evt = 5'b00100;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; halt_evt = 5'b0;
        bus_read(3'd4, rd); check("R7 set wins over clear", rd, 32'h04);

        // R8 / R9 read transfer
        bus_write(3'd1, 32'h0000_0007);
        check("R8 request raised", {31'b0, xfer_req}, 32'h1);
        check("R8 select/dir", {26'b0, xfer_wr, xfer_sel}, 32'h07);
        bus_read(3'd0, rd); check("R8 ready dropped", rd, 32'h0002_0000);
        bus_write(3'd1, 32'h0001_0003);
        check("R8 busy write ignored", {26'b0, xfer_wr, xfer_sel}, 32'h07);
        @(negedge clk); xfer_ack = 1'b1; xfer_rdata = 32'hCAFE_F00D;
        @(negedge clk); xfer_ack = 1'b0;
        check("R8 request released", {31'b0, xfer_req}, 32'h0);
        bus_read(3'd0, rd); check("R8 ready back", rd, 32'h0003_0000);
        bus_read(3'd2, rd); check("R9 captured read", rd, 32'hCAFE_F00D);

        // R9 write transfer
        bus_write(3'd2, 32'h1122_3344);
        bus_write(3'd1, 32'h0001_0009);
        check("R9 write dir/select", {26'b0, xfer_wr, xfer_sel}, 32'h29);
        check("R9 write data out", xfer_wdata, 32'h1122_3344);
        @(negedge clk); xfer_ack = 1'b1; xfer_rdata = 32'hFFFF_FFFF;
        @(negedge clk); xfer_ack = 1'b0;
        bus_read(3'd2, rd); check("R9 data kept on write", rd, 32'h1122_3344);

        finish_run();
    end

endmodule